// File: doc/BRIEF.md
# Seeded Twiddle Factor Generator

This block supplies the twiddle factors for a number theoretic transform (forward or inverse) as a stream. Nothing is read from a twiddle table. Software writes one root of unity for each direction, the forward root and its inverse, into a pair of primary seed registers. A preparation pass then fills a secondary seed file by repeated modular squaring. For each direction, entry k of that file holds the root raised to the power 2^k. The block therefore holds log2 N values per direction instead of N.

When a transform stage begins, the caller gives a stage index and a direction. The block picks the ratio for that stage from the secondary file and emits a geometric progression starting at 1. Each later value is the previous one times the ratio, modulo the prime Q. A valid/ready handshake paces the stream. A single pipelined modular multiplier with fixed latency serves both the preparation pass and the run-time progression. The next product is computed while the current value waits for acceptance.

Top module: `twiddle_seed_gen`

## Requirements
- R1: In the cycle after synchronous reset, `busy`, `tw_valid` and `seeds_ok` are all low.
- R2: A `seed_load` pulse while idle writes `seed_data` as the primary root of the direction in `seed_dir` (0 forward, 1 inverse) and clears `seeds_ok` in the next cycle.
- R3: A `prep_start` pulse while idle raises `busy` and clears `seeds_ok` in the next cycle. It then derives, for both directions, secondary seed k = root^(2^k) mod Q for k from 0 to log2 N - 1. When the pass finishes, `busy` falls and `seeds_ok` is set.
- R4: `start` is accepted only while idle, with `seeds_ok` high, `prep_start` low and `stage` below log2 N. Otherwise it is ignored and `busy` stays low.
- R5: An accepted `start` with stage s produces exactly 2^s twiddles. Twiddle j equals r^j mod Q, with r = root^(N / 2^(s+1)).
- R6: `dir` = 0 takes r from the forward root and `dir` = 1 from the inverse root, both sampled with `start`.
- R7: The first twiddle of every stream is 1.
- R8: While `tw_valid` is high and `tw_ready` is low, `tw_valid` stays high and `tw_data` holds its value.
- R9: Every twiddle presented is below Q.
- R10: In the cycle after the last twiddle is accepted, `busy` and `tw_valid` are low. `tw_valid` is never high without `busy`.
- R11: `seed_load`, `start` and `prep_start` have no effect while `busy` is high. The running stream is unchanged and `seeds_ok` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Write a primary root |
| seed_dir | input | 1 | Root to write: 0 forward, 1 inverse |
| seed_data | input | $clog2(Q) | Root value |
| prep_start | input | 1 | Begin the secondary seed derivation |
| start | input | 1 | Begin a twiddle stream |
| stage | input | $clog2(log2 N) | Transform stage index |
| dir | input | 1 | 0 forward, 1 inverse |
| tw_valid | output | 1 | Twiddle present |
| tw_ready | input | 1 | Consumer accepts twiddle |
| tw_data | output | $clog2(Q) | Twiddle value |
| busy | output | 1 | Preparation or stream in progress |
| seeds_ok | output | 1 | Secondary seeds are current |

## Verification
The assertions check the properties that hold on every cycle. These are the handshake hold, the range of each value below Q, the leading 1 of each stream, the link between `tw_valid` and `busy`, and the effect of a load, a preparation start or a rejected start on `busy` and `seeds_ok`. Only the bench scenarios can show that the arithmetic is right. For a given root, stage and direction, every value of the progression must match and the stream must have the right length. Those scenarios also show that pokes during a stream leave it untouched, with both directed true roots and random roots.

// File: rtl/tfg_pkg.sv
package tfg_pkg;

    localparam int unsigned DEF_N   = 1024;
    localparam int unsigned DEF_Q   = 12289;
    localparam int unsigned DEF_LAT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP_ISSUE,
        ST_PREP_WAIT,
        ST_EMIT,
        ST_WAIT
    } tfg_state_e;

    function automatic logic [31:0] mod_mul(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input logic [31:0] q);
        logic [63:0] prod;
        prod = {32'd0, a} * {32'd0, b};
        return 32'(prod % {32'd0, q});
    endfunction

endpackage

// File: rtl/tfg_mulmod.sv
module tfg_mulmod #(
    parameter int unsigned Q   = tfg_pkg::DEF_Q,
    parameter int unsigned LAT = tfg_pkg::DEF_LAT,
    localparam int unsigned W  = $clog2(Q)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_vld,
    output logic [W-1:0] out_res
);
    logic [LAT-1:0][W-1:0] pdat;
    logic [LAT-1:0]        pvld;

    always_ff @(posedge clk) begin
        pdat[0] <= W'(tfg_pkg::mod_mul(32'(in_a), 32'(in_b), 32'(Q)));
        for (int i = LAT - 1; i > 0; i--) begin
            pdat[i] <= pdat[i-1];
        end
        if (rst) begin
            pvld <= '0;
        end else begin
            pvld <= {pvld[LAT-2:0], in_vld};
        end
    end

    assign out_vld = pvld[LAT-1];
    assign out_res = pdat[LAT-1];
endmodule

// File: rtl/tfg_seed_bank.sv
module tfg_seed_bank #(
    parameter int unsigned N    = tfg_pkg::DEF_N,
    parameter int unsigned Q    = tfg_pkg::DEF_Q,
    localparam int unsigned W   = $clog2(Q),
    localparam int unsigned LOG_N = $clog2(N),
    localparam int unsigned SW  = $clog2(LOG_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prim_we,
    input  logic          prim_dir,
    input  logic [W-1:0]  prim_data,
    input  logic          sec_copy,
    input  logic          sec_we,
    input  logic          sec_dir,
    input  logic [SW-1:0] sec_idx,
    input  logic [W-1:0]  sec_data,
    input  logic          rd_dir,
    input  logic [SW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] dir_rd [2];

    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic [W-1:0]            prim_r;
        logic [LOG_N-1:0][W-1:0] sec_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                prim_r <= '0;
                sec_r  <= '0;
            end else begin
                if (prim_we && (prim_dir == 1'(d))) begin
                    prim_r <= prim_data;
                end
                if (sec_copy) begin
                    sec_r[0] <= prim_r;
                end
                if (sec_we && (sec_dir == 1'(d))) begin
                    sec_r[sec_idx] <= sec_data;
                end
            end
        end

        assign dir_rd[d] = sec_r[rd_idx];
    end

    assign rd_data = rd_dir ? dir_rd[1] : dir_rd[0];
endmodule

// File: rtl/tfg_ctrl.sv
module tfg_ctrl
    import tfg_pkg::*;
#(
    parameter int unsigned N    = DEF_N,
    parameter int unsigned Q    = DEF_Q,
    localparam int unsigned W   = $clog2(Q),
    localparam int unsigned LOG_N = $clog2(N),
    localparam int unsigned SW  = $clog2(LOG_N),
    localparam int unsigned CW  = LOG_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_load,
    input  logic          prep_start,
    input  logic          start,
    input  logic [SW-1:0] stage,
    input  logic          dir,
    input  logic          tw_ready,
    output logic          tw_valid,
    output logic [W-1:0]  tw_data,
    output logic          busy,
    output logic          seeds_ok,
    output logic          prim_we,
    output logic          sec_copy,
    output logic          sec_we,
    output logic          sec_dir,
    output logic [SW-1:0] sec_idx,
    output logic [W-1:0]  sec_data,
    output logic          rd_dir,
    output logic [SW-1:0] rd_idx,
    input  logic [W-1:0]  rd_data,
    output logic          mul_vld,
    output logic [W-1:0]  mul_a,
    output logic [W-1:0]  mul_b,
    input  logic          res_vld,
    input  logic [W-1:0]  res
);
    tfg_state_e    state;
    logic          pd;
    logic [SW-1:0] pk;
    logic [W-1:0]  cur, nxt, ratio;
    logic          nxt_have, issue_req;
    logic [CW-1:0] idx, last;
    logic          idle, prep_go, run_go, in_prep, fire;

    always_comb begin
        idle     = (state == ST_IDLE);
        in_prep  = (state == ST_PREP_ISSUE);
        prim_we  = seed_load && idle;
        prep_go  = idle && prep_start;
        run_go   = idle && !prep_start && start && seeds_ok && (stage < SW'(LOG_N));
        sec_copy = prep_go;
        rd_dir   = in_prep ? pd : dir;
        rd_idx   = in_prep ? SW'(pk - 1'b1) : SW'(SW'(LOG_N - 1) - stage);
        mul_vld  = in_prep || ((state == ST_EMIT) && issue_req);
        mul_a    = in_prep ? rd_data : cur;
        mul_b    = in_prep ? rd_data : ratio;
        sec_we   = (state == ST_PREP_WAIT) && res_vld;
        sec_dir  = pd;
        sec_idx  = pk;
        sec_data = res;
        fire     = (state == ST_EMIT) && tw_ready;
        tw_valid = (state == ST_EMIT);
        tw_data  = cur;
        busy     = !idle;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pd        <= 1'b0;
            pk        <= '0;
            cur       <= '0;
            nxt       <= '0;
            ratio     <= '0;
            nxt_have  <= 1'b0;
            issue_req <= 1'b0;
            idx       <= '0;
            last      <= '0;
            seeds_ok  <= 1'b0;
        end else begin
            if (res_vld && ((state == ST_EMIT) || (state == ST_WAIT))) begin
                nxt      <= res;
                nxt_have <= 1'b1;
            end
            if (prim_we) begin
                seeds_ok <= 1'b0;
            end
            if ((state == ST_EMIT) && issue_req) begin
                issue_req <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (prep_go) begin
                        seeds_ok <= 1'b0;
                        pd       <= 1'b0;
                        pk       <= SW'(1);
                        state    <= ST_PREP_ISSUE;
                    end else if (run_go) begin
                        ratio     <= rd_data;
                        cur       <= W'(1);
                        idx       <= '0;
                        last      <= (CW'(1) << stage) - CW'(1);
                        issue_req <= (stage != '0);
                        nxt_have  <= 1'b0;
                        state     <= ST_EMIT;
                    end
                end
                ST_PREP_ISSUE: state <= ST_PREP_WAIT;
                ST_PREP_WAIT: begin
                    if (res_vld) begin
                        if (pk == SW'(LOG_N - 1)) begin
                            if (pd) begin
                                seeds_ok <= 1'b1;
                                state    <= ST_IDLE;
                            end else begin
                                pd    <= 1'b1;
                                pk    <= SW'(1);
                                state <= ST_PREP_ISSUE;
                            end
                        end else begin
                            pk    <= pk + 1'b1;
                            state <= ST_PREP_ISSUE;
                        end
                    end
                end
                ST_EMIT: begin
                    if (fire) begin
                        if (idx == last) begin
                            state <= ST_IDLE;
                        end else if (nxt_have) begin
                            cur       <= nxt;
                            nxt_have  <= 1'b0;
                            idx       <= idx + 1'b1;
                            issue_req <= ((idx + 1'b1) != last);
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (nxt_have) begin
                        cur       <= nxt;
                        nxt_have  <= 1'b0;
                        idx       <= idx + 1'b1;
                        issue_req <= ((idx + 1'b1) != last);
                        state     <= ST_EMIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twiddle_seed_gen.sv
module twiddle_seed_gen #(
    parameter int unsigned N    = tfg_pkg::DEF_N,
    parameter int unsigned Q    = tfg_pkg::DEF_Q,
    parameter int unsigned LAT  = tfg_pkg::DEF_LAT,
    localparam int unsigned W   = $clog2(Q),
    localparam int unsigned LOG_N = $clog2(N),
    localparam int unsigned SW  = $clog2(LOG_N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_load,
    input  logic          seed_dir,
    input  logic [W-1:0]  seed_data,
    input  logic          prep_start,
    input  logic          start,
    input  logic [SW-1:0] stage,
    input  logic          dir,
    output logic          tw_valid,
    input  logic          tw_ready,
    output logic [W-1:0]  tw_data,
    output logic          busy,
    output logic          seeds_ok
);
    logic          prim_we, sec_copy, sec_we, sec_dir, rd_dir;
    logic [SW-1:0] sec_idx, rd_idx;
    logic [W-1:0]  sec_data, rd_data;
    logic          mul_vld, res_vld;
    logic [W-1:0]  mul_a, mul_b, res;

    tfg_ctrl #(.N(N), .Q(Q)) u_ctrl (
        .clk(clk), .rst(rst),
        .seed_load(seed_load), .prep_start(prep_start), .start(start),
        .stage(stage), .dir(dir), .tw_ready(tw_ready),
        .tw_valid(tw_valid), .tw_data(tw_data), .busy(busy), .seeds_ok(seeds_ok),
        .prim_we(prim_we), .sec_copy(sec_copy), .sec_we(sec_we), .sec_dir(sec_dir),
        .sec_idx(sec_idx), .sec_data(sec_data), .rd_dir(rd_dir), .rd_idx(rd_idx),
        .rd_data(rd_data), .mul_vld(mul_vld), .mul_a(mul_a), .mul_b(mul_b),
        .res_vld(res_vld), .res(res)
    );

    tfg_seed_bank #(.N(N), .Q(Q)) u_bank (
        .clk(clk), .rst(rst),
        .prim_we(prim_we), .prim_dir(seed_dir), .prim_data(seed_data),
        .sec_copy(sec_copy), .sec_we(sec_we), .sec_dir(sec_dir),
        .sec_idx(sec_idx), .sec_data(sec_data),
        .rd_dir(rd_dir), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    tfg_mulmod #(.Q(Q), .LAT(LAT)) u_mul (
        .clk(clk), .rst(rst),
        .in_vld(mul_vld), .in_a(mul_a), .in_b(mul_b),
        .out_vld(res_vld), .out_res(res)
    );
endmodule

// File: rtl/twiddle_seed_gen_chk.sv
module twiddle_seed_gen_chk #(
    parameter int unsigned N    = tfg_pkg::DEF_N,
    parameter int unsigned Q    = tfg_pkg::DEF_Q,
    localparam int unsigned W   = $clog2(Q),
    localparam int unsigned LOG_N = $clog2(N),
    localparam int unsigned SW  = $clog2(LOG_N)
) (
    input logic          clk,
    input logic          rst,
    input logic          seed_load,
    input logic          prep_start,
    input logic          start,
    input logic [SW-1:0] stage,
    input logic          tw_valid,
    input logic          tw_ready,
    input logic [W-1:0]  tw_data,
    input logic          busy,
    input logic          seeds_ok
);
    logic first_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_pend <= 1'b0;
        end else if (start && !busy && seeds_ok && !prep_start && (stage < SW'(LOG_N))) begin
            first_pend <= 1'b1;
        end else if (tw_valid && tw_ready) begin
            first_pend <= 1'b0;
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        tw_valid && !tw_ready |=> tw_valid && $stable(tw_data));

    assert_range_R9: assert property (@(posedge clk) disable iff (rst)
        tw_valid |-> (tw_data < W'(Q)));

    assert_first_one_R7: assert property (@(posedge clk) disable iff (rst)
        first_pend && tw_valid |-> (tw_data == W'(1)));

    assert_valid_busy_R10: assert property (@(posedge clk) disable iff (rst)
        tw_valid |-> busy);

    assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
        seed_load && !busy |=> !seeds_ok);

    assert_prep_busy_R3: assert property (@(posedge clk) disable iff (rst)
        prep_start && !busy |=> busy && !seeds_ok);

    assert_reject_R4: assert property (@(posedge clk) disable iff (rst)
        start && !busy && !seeds_ok && !prep_start |=> !busy);
endmodule

bind twiddle_seed_gen twiddle_seed_gen_chk #(.N(N), .Q(Q)) u_chk (.*);

// File: tb/twiddle_seed_gen_bench.sv
module twiddle_seed_gen_bench;
    localparam int N = 1024;
    localparam int Q = 12289;
    localparam int LAT = 3;
    localparam int W = $clog2(Q);
    localparam int LOG_N = $clog2(N);
    localparam int SW = $clog2(LOG_N);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, seed_load, seed_dir, prep_start, start, dir, tw_ready;
    logic [W-1:0]  seed_data;
    logic [SW-1:0] stage;
    logic          tw_valid, busy, seeds_ok;
    logic [W-1:0]  tw_data;

    int n_chk = 0;
    int n_bad = 0;
    longint root [2];

    twiddle_seed_gen #(.N(N), .Q(Q), .LAT(LAT)) u_twiddle_seed_gen (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_dir(seed_dir),
        .seed_data(seed_data), .prep_start(prep_start), .start(start),
        .stage(stage), .dir(dir), .tw_valid(tw_valid), .tw_ready(tw_ready),
        .tw_data(tw_data), .busy(busy), .seeds_ok(seeds_ok)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint powmod(input longint b, input longint e);
        longint r = 1;
        longint x = b % Q;
        longint k = e;
        while (k > 0) begin
            if (k[0]) r = (r * x) % Q;
            x = (x * x) % Q;
            k = k >> 1;
        end
        return r;
    endfunction

    task automatic load_seed(input bit d, input longint val);
        seed_load = 1'b1; seed_dir = d; seed_data = W'(val);
        @(negedge clk);
        seed_load = 1'b0;
        root[d] = val;
        check(seeds_ok == 1'b0, "R2 load clears seeds_ok", longint'(seeds_ok), 0);
    endtask

    task automatic do_prep();
        int cyc = 0;
        prep_start = 1'b1;
        @(negedge clk);
        prep_start = 1'b0;
        check(busy == 1'b1 && seeds_ok == 1'b0, "R3 prep busy", longint'(busy), 1);
        while (!seeds_ok && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check(seeds_ok == 1'b1 && busy == 1'b0, "R3 prep completes", longint'(seeds_ok), 1);
    endtask

    task automatic run_stream(input int stg, input bit d, input int rdy_pct, input bit poke);
        longint r, exp;
        int got = 0;
        int cyc = 0;
        int total = 1 << stg;
        start = 1'b1; stage = SW'(stg); dir = d;
        @(negedge clk);
        start = 1'b0;
        r = powmod(root[d], longint'(N >> (stg + 1)));
        exp = 1;
        while (got < total && cyc < 30000) begin
            tw_ready = (($urandom % 100) < rdy_pct);
            if (poke && cyc == 4) begin
                start = 1'b1; stage = SW'((stg + 1) % LOG_N); dir = ~d;
                seed_load = 1'b1; seed_dir = d; seed_data = W'(7);
                prep_start = 1'b1;
            end else begin
                start = 1'b0; seed_load = 1'b0; prep_start = 1'b0;
            end
            if (tw_valid && tw_ready) begin
                if (got == 0)
                    check(tw_data == W'(1), "R7 first twiddle", longint'(tw_data), 1);
                check(longint'(tw_data) == exp, d ? "R6 R5 inverse twiddle" : "R5 forward twiddle",
                      longint'(tw_data), exp);
                exp = (exp * r) % Q;
                got++;
            end
            @(negedge clk);
            cyc++;
        end
        tw_ready = 1'b0; start = 1'b0; seed_load = 1'b0; prep_start = 1'b0;
        check(got == total, "R5 stream length", got, total);
        check(busy == 1'b0 && tw_valid == 1'b0, "R10 idle after last", longint'(busy), 0);
        repeat (2) @(negedge clk);
        check(tw_valid == 1'b0, "R10 no extra twiddle", longint'(tw_valid), 0);
        if (poke)
            check(seeds_ok == 1'b1, "R11 pokes ignored while busy", longint'(seeds_ok), 1);
    endtask

    task automatic expect_reject(input int stg, input string req);
        start = 1'b1; stage = SW'(stg); dir = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0 && tw_valid == 1'b0, req, longint'(busy), 0);
        @(negedge clk);
        check(tw_valid == 1'b0, req, longint'(tw_valid), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; seed_load = 1'b0; seed_dir = 1'b0; seed_data = '0;
        prep_start = 1'b0; start = 1'b0; stage = '0; dir = 1'b0; tw_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(busy == 0 && tw_valid == 0 && seeds_ok == 0, "R1 reset state", longint'({busy, tw_valid, seeds_ok}), 0);

        expect_reject(2, "R4 start before prep ignored");

        root[0] = powmod(11, (Q - 1) / N);
        load_seed(1'b0, root[0]);
        load_seed(1'b1, powmod(root[0], N - 1));
        expect_reject(1, "R4 start with stale seeds ignored");
        do_prep();

        run_stream(0, 1'b0, 100, 1'b0);
        run_stream(LOG_N - 1, 1'b0, 100, 1'b0);
        run_stream(LOG_N - 1, 1'b1, 60, 1'b0);
        run_stream(3, 1'b1, 50, 1'b1);
        run_stream(5, 1'b0, 30, 1'b1);
        expect_reject(12, "R4 stage out of range ignored");

        for (int round = 0; round < 3; round++) begin
            load_seed(1'b0, 1 + ($urandom % (Q - 1)));
            load_seed(1'b1, 1 + ($urandom % (Q - 1)));
            do_prep();
            for (int s = 0; s < 4; s++) begin
                run_stream(int'($urandom % LOG_N), 1'($urandom % 2), 20 + int'($urandom % 81), 1'($urandom % 2));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule